// File: doc/BRIEF.md
# CAN Fault Counter and Error Tally

This block holds the fault-confinement state of a CAN controller. It has a transmit fault counter and a receive fault counter, and it derives a receive error-passive flag from the receive counter. The protocol engine moves the counters with strobes. An error strobe adds one or eight, and a success strobe takes one away.

Beside the two fault counters the block keeps a saturating tally of error events. Each time an error strobe arrives, the tally grows by one. This happens even in restricted operation mode, where the fault counters stay frozen against error strobes. Software reads the tally through a packed, read-only 32-bit status word, and that read clears the tally. When an error event arrives while the tally already holds its ceiling, a sticky overflow interrupt is raised. Only a dedicated clear strobe removes it. The live counter values are also brought out as ports.

Top module: `can_fault_tally`

## Requirements
- R1: After reset the transmit count, the receive count, the tally, the passive flag and the overflow interrupt are all zero, and a status read returns 0x00000000.
- R2: While `rd_en` is high and `rd_addr` equals 0x40, `rd_data` shows the status word in the same cycle. Bits 7:0 hold the transmit count, bits 14:8 hold the low seven bits of the receive count, bit 15 holds the passive flag, bits 23:16 hold the tally and bits 31:24 are zero.
- R3: An error strobe adds 1 to its counter when its size bit is 0 and adds 8 when the size bit is 1. The result clamps at 255. An error strobe takes priority over a success strobe to the same counter in the same cycle.
- R4: A success strobe lowers its counter by one. It has no effect at zero and never changes the tally.
- R5: `rx_passive` is 1 exactly when the receive count is 128 or more.
- R6: The tally grows by one in each cycle where at least one error strobe is high. Two strobes in the same cycle count once.
- R7: The tally stops at 255. An error cycle while the tally holds 255 sets `ovf_irq`.
- R8: A status read clears the tally in the next cycle. If an error strobe arrives in the same cycle as the read, the read returns the old tally and the tally becomes 1.
- R9: While `restrict_mode` is high, error strobes leave both fault counters unchanged, but they still advance the tally. Success strobes still apply.
- R10: `ovf_irq` stays set until `ovf_clr` is pulsed. A new overflow in the same cycle as the clear keeps it set.
- R11: A read at any other address returns zero and leaves the tally unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_inc | input | 1 | Transmit error strobe |
| tx_err_big | input | 1 | Step size for the transmit error strobe: 1 means add 8, 0 means add 1 |
| tx_ok_dec | input | 1 | Transmit success strobe, decrement by one |
| rx_err_inc | input | 1 | Receive error strobe |
| rx_err_big | input | 1 | Step size for the receive error strobe: 1 means add 8, 0 means add 1 |
| rx_ok_dec | input | 1 | Receive success strobe, decrement by one |
| restrict_mode | input | 1 | Restricted operation: fault counters ignore error strobes |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| ovf_clr | input | 1 | Clears the overflow interrupt |
| rd_data | output | 32 | Read data |
| ovf_irq | output | 1 | Sticky tally overflow interrupt |
| tx_count | output | 8 | Live transmit fault count |
| rx_count | output | 8 | Live receive fault count (full internal range) |
| rx_passive | output | 1 | Receive error-passive flag |
| log_count | output | 8 | Live error tally |

## Verification
The bench builds the block with its default parameters: a status address of 0x40, a large step of 8, and a passive threshold of 128. With these values the transmit ceiling of 255 is reached in about 32 large steps. The receive passive threshold is crossed after exactly sixteen large steps. At that point the reported 7-bit field wraps to zero while the passive flag rises. The tally reaches its ceiling in a few hundred error cycles. This makes overflow, a clear in the same cycle as a new overflow, and a read in the same cycle as an event all reachable in a short run. The reference model tracks every register behaviourally, and its results are compared with the ports on each clock.

// File: rtl/can_tally_pkg.sv
package can_tally_pkg;
  localparam int TX_W  = 8;
  localparam int RX_W  = 8;
  localparam int LOG_W = 8;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [7:0] pad;
    logic [LOG_W-1:0] tally;
    logic passive;
    logic [6:0] rx_low;
    logic [TX_W-1:0] tx;
  } status_word_t;
endpackage

// File: rtl/can_fault_ctr.sv
module can_fault_ctr #(
  parameter int W = 8,
  parameter int BIG_STEP = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         err_inc,
  input  logic         err_big,
  input  logic         ok_dec,
  input  logic         freeze,
  output logic [W-1:0] count
);
  localparam logic [W:0] STEP_BIG   = (W+1)'(BIG_STEP);
  localparam logic [W:0] STEP_SMALL = (W+1)'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum;
  logic         cnt_en;

  always_comb begin
    sum    = {1'b0, cnt_q} + (err_big ? STEP_BIG : STEP_SMALL);
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (err_inc) begin
      if (!freeze) begin
        cnt_en = 1'b1;
        cnt_d  = sum[W] ? {W{1'b1}} : sum[W-1:0];
      end
    end else if (ok_dec && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/can_err_log.sv
module can_err_log #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         err_evt,
  input  logic         rd_clear,
  input  logic         ovf_clr,
  output logic [W-1:0] tally,
  output logic         ovf
);
  logic [W-1:0] tally_q, tally_d;
  logic         tally_en;
  logic         ovf_q, ovf_d, ovf_en;
  logic         at_top;

  assign at_top = (tally_q == {W{1'b1}});

  always_comb begin
    tally_en = rd_clear || (err_evt && !at_top);
    if (rd_clear) tally_d = err_evt ? W'(1) : '0;
    else          tally_d = tally_q + 1'b1;
  end

  always_comb begin
    ovf_en = (err_evt && at_top) || ovf_clr;
    ovf_d  = err_evt && at_top;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tally_q <= '0;
    else if (tally_en) tally_q <= tally_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf_q <= 1'b0;
    else if (ovf_en) ovf_q <= ovf_d;
  end

  assign tally = tally_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/can_status_pack.sv
module can_status_pack
  import can_tally_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h40
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [TX_W-1:0]   tx,
  input  logic [6:0]        rx_low,
  input  logic              passive,
  input  logic [LOG_W-1:0]  tally,
  output logic              hit,
  output logic [WORD_W-1:0] data
);
  status_word_t word;

  assign hit = rd_en && (rd_addr == STATUS_ADDR);

  always_comb begin
    word.pad     = '0;
    word.tally   = tally;
    word.passive = passive;
    word.rx_low  = rx_low;
    word.tx      = tx;
    data = hit ? word : '0;
  end
endmodule

// File: rtl/can_fault_tally.sv
module can_fault_tally
  import can_tally_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h40,
  parameter int BIG_STEP = 8,
  parameter int PASSIVE_LVL = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_err_inc,
  input  logic              tx_err_big,
  input  logic              tx_ok_dec,
  input  logic              rx_err_inc,
  input  logic              rx_err_big,
  input  logic              rx_ok_dec,
  input  logic              restrict_mode,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              ovf_clr,
  output logic [31:0]       rd_data,
  output logic              ovf_irq,
  output logic [7:0]        tx_count,
  output logic [7:0]        rx_count,
  output logic              rx_passive,
  output logic [7:0]        log_count
);
  localparam logic [RX_W-1:0] PASS_THR = RX_W'(PASSIVE_LVL);

  logic [1:0] inc_v, big_v, dec_v;
  logic [7:0] cnt_v [2];
  logic       rd_hit;
  logic       err_evt;

  assign inc_v = {rx_err_inc, tx_err_inc};
  assign big_v = {rx_err_big, tx_err_big};
  assign dec_v = {rx_ok_dec, tx_ok_dec};

  for (genvar i = 0; i < 2; i++) begin : g_ctr
    can_fault_ctr #(.W(8), .BIG_STEP(BIG_STEP)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .err_inc (inc_v[i]),
      .err_big (big_v[i]),
      .ok_dec  (dec_v[i]),
      .freeze  (restrict_mode),
      .count   (cnt_v[i])
    );
  end

  assign tx_count   = cnt_v[0];
  assign rx_count   = cnt_v[1];
  assign rx_passive = (rx_count >= PASS_THR);
  assign err_evt    = |inc_v;

  can_err_log #(.W(LOG_W)) u_log (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_evt  (err_evt),
    .rd_clear (rd_hit),
    .ovf_clr  (ovf_clr),
    .tally    (log_count),
    .ovf      (ovf_irq)
  );

  can_status_pack #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_pack (
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .tx      (tx_count),
    .rx_low  (rx_count[6:0]),
    .passive (rx_passive),
    .tally   (log_count),
    .hit     (rd_hit),
    .data    (rd_data)
  );
endmodule

// File: rtl/can_fault_tally_chk.sv
module can_fault_tally_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_err_inc,
  input logic              tx_ok_dec,
  input logic              rx_err_inc,
  input logic              rx_ok_dec,
  input logic              restrict_mode,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              ovf_clr,
  input logic [31:0]       rd_data,
  input logic              ovf_irq,
  input logic [7:0]        tx_count,
  input logic [7:0]        rx_count,
  input logic [7:0]        log_count
);
  logic rd_hit_c, evt_c;
  assign rd_hit_c = rd_en && (rd_addr == STATUS_ADDR);
  assign evt_c    = tx_err_inc || rx_err_inc;

  // R2
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_c |-> (rd_data[31:24] == 8'h00));

  // R3
  tx_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == 8'hFF && tx_err_inc && !restrict_mode) |=> (tx_count == 8'hFF));

  // R4
  tx_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == 8'h00 && !tx_err_inc) |=> (tx_count == 8'h00));

  // R7
  tally_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_count == 8'hFF && evt_c && !rd_hit_c) |=> (log_count == 8'hFF && ovf_irq));

  // R8
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit_c && !evt_c) |=> (log_count == 8'h00));

  // R9
  tx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restrict_mode && !tx_ok_dec) |=> $stable(tx_count));

  // R9
  rx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restrict_mode && !rx_ok_dec) |=> $stable(rx_count));

  // R10
  sticky_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_irq && !ovf_clr) |=> ovf_irq);

  // R11
  other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hit_c && !evt_c) |=> $stable(log_count));
endmodule

bind can_fault_tally can_fault_tally_chk #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_chk (.*);

// File: tb/can_fault_tally_test.sv
`timescale 1ns/1ps
module can_fault_tally_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_err_inc = 0, tx_err_big = 0, tx_ok_dec = 0;
  logic rx_err_inc = 0, rx_err_big = 0, rx_ok_dec = 0;
  logic restrict_mode = 0, rd_en = 0, ovf_clr = 0;
  logic [7:0] rd_addr = 8'h00;
  logic [31:0] rd_data;
  logic ovf_irq, rx_passive;
  logic [7:0] tx_count, rx_count, log_count;

  int checks = 0;
  int errors = 0;
  int m_tx = 0, m_rx = 0, m_log = 0;
  bit m_ovf = 0;

  always #2.5 clk = ~clk;

  can_fault_tally uut (.*);

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    if (rd_en && rd_addr == 8'h40)
      return {8'h00, 8'(m_log), (m_rx >= 128), 7'(m_rx % 128), 8'(m_tx)};
    return 32'h0;
  endfunction

  task automatic idle();
    tx_err_inc = 0; tx_err_big = 0; tx_ok_dec = 0;
    rx_err_inc = 0; rx_err_big = 0; rx_ok_dec = 0;
    rd_en = 0; rd_addr = 8'h00; ovf_clr = 0;
  endtask

  // compare ports to the model, then advance model and clock one cycle
  task automatic tick();
    bit ev, rd;
    #1;
    chk("R3 tx", tx_count, m_tx);
    chk("R3 rx", rx_count, m_rx);
    chk("R5 passive", rx_passive, m_rx >= 128);
    chk("R6 tally", log_count, m_log);
    chk("R7 ovf", ovf_irq, m_ovf);
    chk("R2 rd_data", rd_data, exp_word());
    ev = tx_err_inc || rx_err_inc;
    rd = rd_en && rd_addr == 8'h40;
    if (ev && m_log == 255) m_ovf = 1;
    else if (ovf_clr) m_ovf = 0;
    if (rd) m_log = ev ? 1 : 0;
    else if (ev && m_log < 255) m_log++;
    if (tx_err_inc) begin
      if (!restrict_mode) m_tx = (m_tx + (tx_err_big ? 8 : 1) > 255) ? 255 : m_tx + (tx_err_big ? 8 : 1);
    end else if (tx_ok_dec && m_tx > 0) m_tx--;
    if (rx_err_inc) begin
      if (!restrict_mode) m_rx = (m_rx + (rx_err_big ? 8 : 1) > 255) ? 255 : m_rx + (rx_err_big ? 8 : 1);
    end else if (rx_ok_dec && m_rx > 0) m_rx--;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tx", tx_count, 0);
    chk("R1 rx", rx_count, 0);
    chk("R1 tally", log_count, 0);
    chk("R1 ovf", ovf_irq, 0);
    rst_n = 1'b1;
    rd_en = 1; rd_addr = 8'h40; #1;
    chk("R1 word", rd_data, 0);
    tick(); idle();

    // R3 small and large steps
    repeat (3) begin tx_err_inc = 1; tick(); end
    tx_err_big = 1;
    repeat (2) tick();
    idle();
    chk("R3 tx 19", tx_count, 19);
    // R3 error beats success in same cycle
    tx_err_inc = 1; tx_ok_dec = 1; tick(); idle();
    chk("R3 priority", tx_count, 20);
    // R4 decrement to floor
    repeat (23) begin tx_ok_dec = 1; tick(); end
    idle();
    chk("R4 floor", tx_count, 0);
    chk("R4 tally untouched", log_count, 6);
    // R3 saturation
    repeat (40) begin tx_err_inc = 1; tx_err_big = 1; tick(); end
    idle();
    chk("R3 ceiling", tx_count, 255);

    // R5 passive threshold
    repeat (15) begin rx_err_inc = 1; rx_err_big = 1; tick(); end
    idle();
    chk("R5 below", rx_passive, 0);
    rx_err_inc = 1; rx_err_big = 1; tick(); idle();
    rd_en = 1; rd_addr = 8'h40; #1;
    chk("R2 rx field wraps", rd_data[14:8], 0);
    chk("R5 passive bit", rd_data[15], 1);
    tick(); idle();
    // R8 clear on read
    chk("R8 cleared", log_count, 0);
    rx_ok_dec = 1; tick(); idle();
    chk("R5 back below", rx_passive, 0);

    // R9 restricted mode
    restrict_mode = 1;
    repeat (5) begin tx_err_inc = 1; tx_err_big = 1; rx_err_inc = 1; tick(); end
    idle();
    chk("R9 tx frozen", tx_count, 255);
    chk("R9 rx frozen", rx_count, 127);
    chk("R9 tally counts", log_count, 5);
    rx_ok_dec = 1; tick(); idle();
    chk("R9 dec applies", rx_count, 126);

    // R11 other address
    rd_en = 1; rd_addr = 8'h44; #1;
    chk("R11 zero data", rd_data, 0);
    tick(); idle();
    chk("R11 tally kept", log_count, 5);

    // R6 two strobes count once
    tx_err_inc = 1; rx_err_inc = 1; tick(); idle();
    chk("R6 once", log_count, 6);

    // R7 saturate and overflow
    repeat (249) begin rx_err_inc = 1; tick(); end
    idle();
    chk("R7 at top", log_count, 255);
    chk("R7 no ovf yet", ovf_irq, 0);
    tx_err_inc = 1; tick(); idle();
    chk("R7 ovf set", ovf_irq, 1);
    chk("R7 tally held", log_count, 255);
    repeat (3) tick();
    chk("R10 sticky", ovf_irq, 1);
    ovf_clr = 1; tick(); idle();
    chk("R10 cleared", ovf_irq, 0);
    ovf_clr = 1; rx_err_inc = 1; tick(); idle();
    chk("R10 set wins", ovf_irq, 1);

    // R8 read with event
    rd_en = 1; rd_addr = 8'h40; rx_err_inc = 1; #1;
    chk("R8 old value", rd_data[23:16], 255);
    tick(); idle();
    chk("R8 ends at 1", log_count, 1);
    restrict_mode = 0;
    repeat (2) tick();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule